// File: doc/BRIEF.md
# Segmented Linear Address Generator

This block turns an operand addressing request into a linear memory address. Each request carries a mode code and the values it may need: a segment base, a base register, an index register, a two-bit scale code, a signed displacement field and the program counter. Nine modes are defined. Some add the segment base to a mix of base, index (scaled or not) and displacement. One adds the displacement to the program counter without the segment base. Immediate and register operands need no memory address and are flagged as such.

The sum is formed in one combinational datapath. It is captured in an output register on the clock edge where the input valid is high, so the result is seen one cycle after the request is accepted. A separate flag reports whether a memory address was produced. Segment limit checks, paging and the operand fetch belong to other blocks.

Top module: `seg_addr_gen`

## Requirements
- R1: While `rst` is high and after it is released (before any accepted request), `out_valid`, `addr_valid` and `lin_addr` are all zero.
- R2: `out_valid` equals the value `in_valid` had at the previous rising clock edge.
- R3: On an edge where `in_valid` is low, `lin_addr` and `addr_valid` keep their previous values, whatever the other inputs hold.
- R4: Mode 0 (immediate), mode 1 (register) and the reserved codes 9 to 15 give `addr_valid` = 0 and `lin_addr` = 0. Every other mode gives `addr_valid` = 1.
- R5: Mode 2 (displacement only): address = segment base + displacement.
- R6: Mode 3 (base only): address = segment base + base register. The index and displacement are ignored.
- R7: Mode 4 (base with displacement): address = segment base + base + displacement.
- R8: Mode 5 (scaled index with displacement): address = segment base + (index × scale) + displacement.
- R9: Mode 6 (base, index and displacement): address = segment base + base + index + displacement. The index is not scaled, whatever the scale code is.
- R10: Mode 7 (base, scaled index and displacement): address = segment base + (index × scale) + base + displacement.
- R11: Mode 8 (PC-relative): address = program counter + displacement. The segment base is not added.
- R12: Scale codes 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8.
- R13: The displacement field is sign-extended to the address width before it is added. All sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request accepted on this edge |
| mode | input | 4 | Addressing mode code (0..8 used) |
| seg_base | input | 32 | Segment base value |
| base_reg | input | 32 | Base register value |
| index_reg | input | 32 | Index register value |
| scale_code | input | 2 | Index scale selector: 1, 2, 4, 8 |
| disp | input | 16 | Signed displacement field |
| pc | input | 32 | Program counter |
| out_valid | output | 1 | Result registered on previous edge |
| lin_addr | output | 32 | Linear address |
| addr_valid | output | 1 | A memory address was produced |

## Verification
On every cycle the assertions check several things: the one-cycle tracking of the valid signal, the holding of results while no request is accepted, the cleared address and flag for the no-address codes, and the PC-relative sum. The formula of each segment-based mode can only be shown by the bench. It sweeps every mode code against every scale code over operand sets that include negative displacements and carries out of the top bit. It computes each expected address from the mode formulas and also confirms that terms a mode does not use have no effect.

// File: rtl/seg_addr_gen_pkg.sv
package seg_addr_gen_pkg;
  localparam int MODE_W = 4;
  localparam int SCALE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    AM_IMM        = 4'd0,
    AM_REG        = 4'd1,
    AM_DISP       = 4'd2,
    AM_BASE       = 4'd3,
    AM_BASE_DISP  = 4'd4,
    AM_SIDX_DISP  = 4'd5,
    AM_BIDX_DISP  = 4'd6,
    AM_BSIDX_DISP = 4'd7,
    AM_REL        = 4'd8
  } am_mode_e;

  // Which terms enter the sum for a given mode.
  typedef struct packed {
    logic use_seg;
    logic use_base;
    logic use_idx;
    logic scaled;
    logic use_disp;
    logic use_pc;
    logic mem;
  } term_sel_t;
endpackage

// File: rtl/seg_addr_gen_decode.sv
module seg_addr_gen_decode
  import seg_addr_gen_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output term_sel_t         sel_o
);
  always_comb begin
    sel_o = '0;
    case (mode_i)
      AM_DISP: begin
        sel_o.use_seg = 1'b1; sel_o.use_disp = 1'b1; sel_o.mem = 1'b1;
      end
      AM_BASE: begin
        sel_o.use_seg = 1'b1; sel_o.use_base = 1'b1; sel_o.mem = 1'b1;
      end
      AM_BASE_DISP: begin
        sel_o.use_seg = 1'b1; sel_o.use_base = 1'b1;
        sel_o.use_disp = 1'b1; sel_o.mem = 1'b1;
      end
      AM_SIDX_DISP: begin
        sel_o.use_seg = 1'b1; sel_o.use_idx = 1'b1; sel_o.scaled = 1'b1;
        sel_o.use_disp = 1'b1; sel_o.mem = 1'b1;
      end
      AM_BIDX_DISP: begin
        sel_o.use_seg = 1'b1; sel_o.use_base = 1'b1; sel_o.use_idx = 1'b1;
        sel_o.use_disp = 1'b1; sel_o.mem = 1'b1;
      end
      AM_BSIDX_DISP: begin
        sel_o.use_seg = 1'b1; sel_o.use_base = 1'b1; sel_o.use_idx = 1'b1;
        sel_o.scaled = 1'b1; sel_o.use_disp = 1'b1; sel_o.mem = 1'b1;
      end
      AM_REL: begin
        sel_o.use_pc = 1'b1; sel_o.use_disp = 1'b1; sel_o.mem = 1'b1;
      end
      default: sel_o = '0;  // immediate, register, reserved
    endcase
  end
endmodule

// File: rtl/seg_addr_gen_scaler.sv
module seg_addr_gen_scaler #(
  parameter int AW      = 32,
  parameter int SCALE_W = 2
) (
  input  logic [AW-1:0]      idx_i,
  input  logic [SCALE_W-1:0] code_i,
  input  logic               scaled_i,
  output logic [AW-1:0]      idx_o
);
  localparam int NSCALE = 1 << SCALE_W;

  logic [AW-1:0] cand [NSCALE];

  // One shifted copy of the index per scale code.
  for (genvar k = 0; k < NSCALE; k++) begin : g_shift
    assign cand[k] = idx_i << k;
  end

  assign idx_o = scaled_i ? cand[code_i] : idx_i;
endmodule

// File: rtl/seg_addr_gen_sum.sv
module seg_addr_gen_sum
  import seg_addr_gen_pkg::*;
#(
  parameter int AW = 32
) (
  input  term_sel_t     sel_i,
  input  logic [AW-1:0] seg_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] idx_i,
  input  logic [AW-1:0] disp_i,
  input  logic [AW-1:0] pc_i,
  output logic [AW-1:0] sum_o
);
  logic [AW-1:0] origin, t_base, t_idx, t_disp;

  // Segment base and PC are mutually exclusive origins.
  assign origin = sel_i.use_pc  ? pc_i :
                  sel_i.use_seg ? seg_i : '0;
  assign t_base = sel_i.use_base ? base_i : '0;
  assign t_idx  = sel_i.use_idx  ? idx_i  : '0;
  assign t_disp = sel_i.use_disp ? disp_i : '0;

  assign sum_o = (origin + t_base) + (t_idx + t_disp);
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_gen_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [MODE_W-1:0]  mode,
  input  logic [AW-1:0]      seg_base,
  input  logic [AW-1:0]      base_reg,
  input  logic [AW-1:0]      index_reg,
  input  logic [SCALE_W-1:0] scale_code,
  input  logic [DW-1:0]      disp,
  input  logic [AW-1:0]      pc,
  output logic               out_valid,
  output logic [AW-1:0]      lin_addr,
  output logic               addr_valid
);
  localparam int EXT_W = AW - DW;

  term_sel_t     sel;
  logic [AW-1:0] disp_ext, idx_eff, sum;

  assign disp_ext = {{EXT_W{disp[DW-1]}}, disp};

  seg_addr_gen_decode u_decode (
    .mode_i (mode),
    .sel_o  (sel)
  );

  seg_addr_gen_scaler #(.AW(AW), .SCALE_W(SCALE_W)) u_scaler (
    .idx_i    (index_reg),
    .code_i   (scale_code),
    .scaled_i (sel.scaled),
    .idx_o    (idx_eff)
  );

  seg_addr_gen_sum #(.AW(AW)) u_sum (
    .sel_i  (sel),
    .seg_i  (seg_base),
    .base_i (base_reg),
    .idx_i  (idx_eff),
    .disp_i (disp_ext),
    .pc_i   (pc),
    .sum_o  (sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      lin_addr   <= '0;
      addr_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        lin_addr   <= sel.mem ? sum : '0;
        addr_valid <= sel.mem;
      end
    end
  end

  // R2: output valid tracks input valid one cycle later
  assert_out_valid_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_out_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R3: no accepted request leaves the result untouched
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(lin_addr) && $stable(addr_valid)));

  // R4: immediate, register and reserved codes yield no address
  assert_no_addr_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (mode < 4'd2 || mode > 4'd8)) |=> (!addr_valid && lin_addr == '0));
  assert_mem_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode >= 4'd2 && mode <= 4'd8) |=> addr_valid);

  // R11: PC-relative result excludes segment base
  assert_rel_R11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 4'd8) |=> (lin_addr == $past(pc) + $past(disp_ext)));
endmodule

// File: tb/seg_addr_gen_tb_top.sv
module seg_addr_gen_tb_top;
  localparam int AW = 32;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [3:0]    mode;
  logic [AW-1:0] seg_base, base_reg, index_reg, pc;
  logic [1:0]    scale_code;
  logic [DW-1:0] disp;
  logic          out_valid, addr_valid;
  logic [AW-1:0] lin_addr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  seg_addr_gen #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
    .seg_base(seg_base), .base_reg(base_reg), .index_reg(index_reg),
    .scale_code(scale_code), .disp(disp), .pc(pc),
    .out_valid(out_valid), .lin_addr(lin_addr), .addr_valid(addr_valid)
  );

  task automatic check(input string req, input logic ov, input logic av,
                       input logic [AW-1:0] la, input logic eov,
                       input logic eav, input logic [AW-1:0] ela);
    n_cmp++;
    if (ov !== eov || av !== eav || la !== ela) begin
      n_bad++;
      $display("FAIL %s: got ov=%0b av=%0b addr=%h, expected ov=%0b av=%0b addr=%h",
               req, ov, av, la, eov, eav, ela);
    end
  endtask

  function automatic string tag_of(input int m);
    case (m)
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8 R12";
      6: return "R9";
      7: return "R10 R12";
      8: return "R11";
      default: return "R4";
    endcase
  endfunction

  // Expected address from the mode formulas (R5..R13).
  function automatic logic [AW:0] expect_of(input int m, input logic [AW-1:0] s,
      input logic [AW-1:0] b, input logic [AW-1:0] x, input logic [1:0] sc,
      input logic [DW-1:0] d, input logic [AW-1:0] p);
    logic [AW-1:0] dx, xs;
    dx = AW'($signed(d));           // R13 sign extension
    xs = x * (AW'(1) << sc);        // R12 scale 1/2/4/8
    case (m)
      2: return {1'b1, s + dx};
      3: return {1'b1, s + b};
      4: return {1'b1, s + b + dx};
      5: return {1'b1, s + xs + dx};
      6: return {1'b1, s + b + x + dx};
      7: return {1'b1, s + xs + b + dx};
      8: return {1'b1, p + dx};
      default: return '0;
    endcase
  endfunction

  task automatic load_vec(input int v);
    case (v)
      0: begin seg_base = 32'h0001_0000; base_reg = 32'h0000_0100;
               index_reg = 32'h0000_0010; disp = 16'h0020; pc = 32'h0000_4000; end
      1: begin seg_base = 32'h2000_0000; base_reg = 32'h0123_4567;
               index_reg = 32'h0000_0333; disp = 16'hFFF0; pc = 32'h8000_0000; end  // R13 negative
      2: begin seg_base = 32'hFFFF_FFF0; base_reg = 32'h0000_0020;
               index_reg = 32'h8000_0001; disp = 16'h8000; pc = 32'h0000_0004; end  // R13 wrap
      3: begin seg_base = 32'h0000_0000; base_reg = 32'hFFFF_FFFF;
               index_reg = 32'hFFFF_FFFF; disp = 16'h7FFF; pc = 32'hFFFF_FFFF; end
      4: begin seg_base = 32'hA5A5_0000; base_reg = 32'h0000_5A5A;
               index_reg = 32'h1111_1111; disp = 16'h0001; pc = 32'h1234_5678; end
      default: begin seg_base = 32'h0F0F_0F0F; base_reg = 32'h7000_0000;
               index_reg = 32'h2000_0003; disp = 16'hC000; pc = 32'h0000_0000; end
    endcase
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got no finish, expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [AW:0] e;
    logic [AW-1:0] last_a;
    logic last_v;
    rst = 1'b1; in_valid = 1'b1; mode = 4'd2; scale_code = 2'd0;
    load_vec(0);
    repeat (3) @(negedge clk);
    check("R1", out_valid, addr_valid, lin_addr, 1'b0, 1'b0, '0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check("R1", out_valid, addr_valid, lin_addr, 1'b0, 1'b0, '0);

    for (int v = 0; v < 6; v++) begin
      for (int m = 0; m < 16; m++) begin
        for (int sc = 0; sc < 4; sc++) begin
          load_vec(v);
          mode = 4'(m); scale_code = 2'(sc); in_valid = 1'b1;
          e = expect_of(m, seg_base, base_reg, index_reg, 2'(sc), disp, pc);
          @(negedge clk);
          check({tag_of(m), (v == 1 || v == 2) ? " R13" : "", " R2"},
                out_valid, addr_valid, lin_addr, 1'b1, e[AW], e[AW-1:0]);
        end
      end
      // R3: change every input with in_valid low; result must stay
      last_a = lin_addr; last_v = addr_valid;
      in_valid = 1'b0; mode = 4'd8; pc = ~pc; seg_base = ~seg_base; disp = ~disp;
      @(negedge clk);
      check("R3 R2", out_valid, addr_valid, lin_addr, 1'b0, last_v, last_a);
      mode = 4'd0;
      @(negedge clk);
      check("R3", out_valid, addr_valid, lin_addr, 1'b0, last_v, last_a);
    end

    // R6: index/displacement have no effect in base-only mode
    for (int k = 0; k < 4; k++) begin
      load_vec(0);
      index_reg = 32'h1 << (8 * k); disp = 16'(k * 16'h1111); mode = 4'd3;
      scale_code = 2'(k); in_valid = 1'b1;
      @(negedge clk);
      check("R6", out_valid, addr_valid, lin_addr, 1'b1, 1'b1, 32'h0001_0100);
    end

    // R1: reset clears registered outputs again
    rst = 1'b1;
    @(negedge clk);
    check("R1", out_valid, addr_valid, lin_addr, 1'b0, 1'b0, '0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule